// File: doc/BRIEF.md
# Two-Port Synchronous Static Memory with Address Counters

This block is a true two-port synchronous memory. Two ports, A and B, run on one shared clock and can read or write any word at any time, the same word included. Each port is W bits wide and split into byte lanes of LANE_W bits (default two lanes of 9 bits, so 18 bits). Every control, address, data and lane-enable input is captured on the rising clock edge.

Each port owns an address register. On each edge it either takes the external address, steps by one, replays the last address it was given, or holds. This lets a port stream through consecutive words without presenting each address. A port is selected only through two chip enables of opposite polarity, so banks can be stacked without decode logic.

The read path on each port is set by a static mode input. In flow-through mode a read shows its data in the cycle after its edge. In pipelined mode the data comes one registered cycle later, and the output stays driven for one cycle after a deselect. When both ports hit the same word in the same cycle and at least one of them writes, an active-low collision flag pulses on both ports. There is no back-pressure: the block accepts an access on every cycle, and the read data carries no handshake. Its timing is fixed by the mode input.

Top module: `dp_ram_core`

## Requirements
- R1: A port is selected only when its `ce0_n` input is 0 and its `ce1` input is 1. A deselected cycle writes nothing, and its read lanes stay undriven (`dout_en` = 0).
- R2: A selected cycle with `rw_n` = 0 writes the word at the port's effective address. Bits [8:0] are written only when `be_n[0]` = 0, and bits [17:9] only when `be_n[1]` = 0. A write cycle drives no read lanes.
- R3: With `flow` = 1, a selected read captured at edge k shows the word on `dout` after edge k. Each lane i has `dout_en[i]` = 1 exactly when `be_n[i]` was 0.
- R4: With `flow` = 0, the same read shows its data and lane enables only after edge k+1.
- R5: With `ads_n` = 0, the effective address is the `addr` input sampled at that edge.
- R6: With `ads_n` = 1, `rpt_n` = 1 and `cnten_n` = 0, the effective address is the previous one plus one. It wraps from DEPTH-1 to 0.
- R7: With `ads_n` = 1 and `rpt_n` = 0, the effective address is the last address loaded through `ads_n`. The priority order is `ads_n`, then `rpt_n`, then `cnten_n`.
- R8: With `ads_n`, `rpt_n` and `cnten_n` all 1, the effective address is held.
- R9: In pipelined mode, a read followed by a deselect keeps the lanes driven for one more cycle, then releases them. In flow-through mode the lanes are released right after the deselect edge.
- R10: `oe_n` = 1 forces `dout_en` to 0 at once, without a clock edge. The read pipeline keeps advancing, so data appears as soon as `oe_n` returns to 0.
- R11: `a_col_n` and `b_col_n` go to 0 for the one cycle after an edge where both ports were selected, their effective addresses matched and at least one port wrote. Otherwise they are 1.
- R12: When both ports write the same lanes of the same word at one edge, port A's data is stored.
- R13: After reset, both `dout_en` are 0, both collision flags are 1 and both address registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_rw_n | input | 1 | Port A 1 = read, 0 = write |
| a_be_n | input | LANES | Port A lane enables, active low |
| a_addr | input | AW | Port A external address |
| a_ads_n | input | 1 | Port A address strobe, active low |
| a_cnten_n | input | 1 | Port A count enable, active low |
| a_rpt_n | input | 1 | Port A replay strobed address, active low |
| a_oe_n | input | 1 | Port A output enable, asynchronous, active low |
| a_flow | input | 1 | Port A mode, 1 = flow-through, 0 = pipelined |
| a_din | input | W | Port A write data |
| a_dout | output | W | Port A read data |
| a_dout_en | output | LANES | Port A per-lane drive enable |
| a_col_n | output | 1 | Port A collision flag, active low |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_rw_n | input | 1 | Port B 1 = read, 0 = write |
| b_be_n | input | LANES | Port B lane enables, active low |
| b_addr | input | AW | Port B external address |
| b_ads_n | input | 1 | Port B address strobe, active low |
| b_cnten_n | input | 1 | Port B count enable, active low |
| b_rpt_n | input | 1 | Port B replay strobed address, active low |
| b_oe_n | input | 1 | Port B output enable, asynchronous, active low |
| b_flow | input | 1 | Port B mode, 1 = flow-through, 0 = pipelined |
| b_din | input | W | Port B write data |
| b_dout | output | W | Port B read data |
| b_dout_en | output | LANES | Port B per-lane drive enable |
| b_col_n | output | 1 | Port B collision flag, active low |

## Verification
The bench counts past the top word. A counter that does not wrap would write outside the array, and the data written at address 0 would be missing. It checks that a replay returns to the last strobed word and not to the last counted one, and that a strobe wins over a replay in the same cycle. It also writes a single lane and reads the word back, which exposes inverted lane enables or swapped lane ranges. The pipelined port is checked in the cycle right after a deselect, so a design without the extra drive cycle, or one that releases the lanes late, gives the wrong enables. Finally, both ports write one word together: a wrong flag pulse width or a wrong write priority shows as a stuck flag or as port B's data.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
package dp_pkg;
  typedef enum logic [1:0] {
    ADR_HOLD   = 2'd0,
    ADR_LOAD   = 2'd1,
    ADR_REPLAY = 2'd2,
    ADR_STEP   = 2'd3
  } adr_op_e;

  function automatic adr_op_e adr_decode(input logic ads_n, input logic rpt_n,
                                         input logic cnten_n);
    if (!ads_n)        return ADR_LOAD;
    else if (!rpt_n)   return ADR_REPLAY;
    else if (!cnten_n) return ADR_STEP;
    else               return ADR_HOLD;
  endfunction
endpackage

// File: rtl/dp_addr_ctr.sv
`timescale 1ns/1ps
module dp_addr_ctr #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ads_n,
  input  logic          rpt_n,
  input  logic          cnten_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_eff,
  output logic [AW-1:0] addr_q
);
  import dp_pkg::*;

  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  adr_op_e       op;
  logic [AW-1:0] strobed_q;

  always_comb begin
    op = adr_decode(ads_n, rpt_n, cnten_n);
    unique case (op)
      ADR_LOAD:   addr_eff = ext_addr;
      ADR_REPLAY: addr_eff = strobed_q;
      ADR_STEP:   addr_eff = (addr_q == TOP) ? '0 : addr_q + AW'(1);
      default:    addr_eff = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      strobed_q <= '0;
    end else begin
      addr_q <= addr_eff;
      if (op == ADR_LOAD) strobed_q <= ext_addr;
    end
  end
endmodule

// File: rtl/dp_mem_array.sv
`timescale 1ns/1ps
module dp_mem_array #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DEPTH  = 64,
  localparam int W  = LANE_W * LANES,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic [1:0]            wr_en,
  input  logic [1:0][LANES-1:0] lane_we,
  input  logic [1:0][AW-1:0]    wr_addr,
  input  logic [1:0][W-1:0]     wr_data,
  input  logic [1:0][AW-1:0]    rd_addr,
  output logic [1:0][W-1:0]     rd_data
);
  logic [W-1:0] mem [DEPTH];

  // Port 1 is applied first so that port 0 (A) wins on equal addresses.
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[p] && lane_we[p][l])
          mem[wr_addr[p]][l*LANE_W +: LANE_W] <= wr_data[p][l*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end
endmodule

// File: rtl/dp_out_path.sv
`timescale 1ns/1ps
module dp_out_path #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow,
  input  logic             oe_n,
  input  logic [LANES-1:0] lanes_q,
  input  logic [W-1:0]     rd_data,
  output logic [W-1:0]     dout,
  output logic [LANES-1:0] dout_en
);
  logic [W-1:0]     pipe_data;
  logic [LANES-1:0] pipe_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_data <= '0;
      pipe_en   <= '0;
    end else begin
      pipe_data <= rd_data;
      pipe_en   <= lanes_q;
    end
  end

  always_comb begin
    if (flow) begin
      dout    = rd_data;
      dout_en = lanes_q;
    end else begin
      dout    = pipe_data;
      dout_en = pipe_en;
    end
    if (oe_n) dout_en = '0;
  end
endmodule

// File: rtl/dp_ram_core.sv
`timescale 1ns/1ps
module dp_ram_core #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DEPTH  = 64,
  localparam int W  = LANE_W * LANES,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_ce0_n,
  input  logic             a_ce1,
  input  logic             a_rw_n,
  input  logic [LANES-1:0] a_be_n,
  input  logic [AW-1:0]    a_addr,
  input  logic             a_ads_n,
  input  logic             a_cnten_n,
  input  logic             a_rpt_n,
  input  logic             a_oe_n,
  input  logic             a_flow,
  input  logic [W-1:0]     a_din,
  output logic [W-1:0]     a_dout,
  output logic [LANES-1:0] a_dout_en,
  output logic             a_col_n,
  input  logic             b_ce0_n,
  input  logic             b_ce1,
  input  logic             b_rw_n,
  input  logic [LANES-1:0] b_be_n,
  input  logic [AW-1:0]    b_addr,
  input  logic             b_ads_n,
  input  logic             b_cnten_n,
  input  logic             b_rpt_n,
  input  logic             b_oe_n,
  input  logic             b_flow,
  input  logic [W-1:0]     b_din,
  output logic [W-1:0]     b_dout,
  output logic [LANES-1:0] b_dout_en,
  output logic             b_col_n
);
  logic [1:0]            ce0_n_v, ce1_v, rw_n_v, ads_n_v, cnt_n_v, rpt_n_v, oe_n_v, flow_v;
  logic [1:0][LANES-1:0] be_n_v, lanes_q, lane_we, en_v;
  logic [1:0][AW-1:0]    addr_v, addr_eff, addr_q;
  logic [1:0][W-1:0]     din_v, rd_data, dout_v;
  logic [1:0]            sel, wr_en;
  logic                  col_q;

  assign ce0_n_v = {b_ce0_n, a_ce0_n};
  assign ce1_v   = {b_ce1, a_ce1};
  assign rw_n_v  = {b_rw_n, a_rw_n};
  assign ads_n_v = {b_ads_n, a_ads_n};
  assign cnt_n_v = {b_cnten_n, a_cnten_n};
  assign rpt_n_v = {b_rpt_n, a_rpt_n};
  assign oe_n_v  = {b_oe_n, a_oe_n};
  assign flow_v  = {b_flow, a_flow};
  assign be_n_v  = {b_be_n, a_be_n};
  assign addr_v  = {b_addr, a_addr};
  assign din_v   = {b_din, a_din};

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign sel[p]     = !ce0_n_v[p] && ce1_v[p];
    assign wr_en[p]   = sel[p] && !rw_n_v[p];
    assign lane_we[p] = ~be_n_v[p];

    dp_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ads_n    (ads_n_v[p]),
      .rpt_n    (rpt_n_v[p]),
      .cnten_n  (cnt_n_v[p]),
      .ext_addr (addr_v[p]),
      .addr_eff (addr_eff[p]),
      .addr_q   (addr_q[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lanes_q[p] <= '0;
      else        lanes_q[p] <= (sel[p] && rw_n_v[p]) ? ~be_n_v[p] : '0;
    end

    dp_out_path #(.LANE_W(LANE_W), .LANES(LANES)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .flow    (flow_v[p]),
      .oe_n    (oe_n_v[p]),
      .lanes_q (lanes_q[p]),
      .rd_data (rd_data[p]),
      .dout    (dout_v[p]),
      .dout_en (en_v[p])
    );
  end

  dp_mem_array #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .lane_we (lane_we),
    .wr_addr (addr_eff),
    .wr_data (din_v),
    .rd_addr (addr_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= 1'b0;
    else        col_q <= &sel && (addr_eff[0] == addr_eff[1]) && |wr_en;
  end

  assign a_dout    = dout_v[0];
  assign b_dout    = dout_v[1];
  assign a_dout_en = en_v[0];
  assign b_dout_en = en_v[1];
  assign a_col_n   = !col_q;
  assign b_col_n   = !col_q;
endmodule

// File: rtl/dp_ram_chk.sv
`timescale 1ns/1ps
module dp_ram_chk #(
  parameter int LANES = 2,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_ce0_n,
  input logic             a_ce1,
  input logic             a_rw_n,
  input logic             a_ads_n,
  input logic [AW-1:0]    a_addr,
  input logic             a_oe_n,
  input logic             a_flow,
  input logic [LANES-1:0] a_dout_en,
  input logic             a_col_n,
  input logic             b_ce0_n,
  input logic             b_ce1,
  input logic             b_rw_n,
  input logic             b_ads_n,
  input logic [AW-1:0]    b_addr,
  input logic             b_flow,
  input logic [LANES-1:0] b_dout_en,
  input logic             b_col_n
);
  logic [1:0] since;
  logic       seen1, seen2, a_sel, b_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end
  assign seen1 = since >= 2'd1;
  assign seen2 = since >= 2'd2;
  assign a_sel = !a_ce0_n && a_ce1;
  assign b_sel = !b_ce0_n && b_ce1;

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && a_flow && !$past(a_sel)) |-> (a_dout_en == '0)); // R1
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && a_flow && $past(!a_rw_n)) |-> (a_dout_en == '0)); // R2
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe_n |-> (a_dout_en == '0)); // R10
  AST_PIPE_DCD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen2 && !b_flow && !$past(b_sel, 2)) |-> (b_dout_en == '0)); // R9
  AST_COL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && $past(a_sel && b_sel && !a_ads_n && !b_ads_n && a_addr == b_addr
                    && !(a_rw_n && b_rw_n))) |-> (!a_col_n && !b_col_n)); // R11
  AST_COL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen1 && !a_col_n) |-> $past(a_sel && b_sel && !(a_rw_n && b_rw_n))); // R11
endmodule

bind dp_ram_core dp_ram_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_ce0_n   (a_ce0_n),
  .a_ce1     (a_ce1),
  .a_rw_n    (a_rw_n),
  .a_ads_n   (a_ads_n),
  .a_addr    (a_addr),
  .a_oe_n    (a_oe_n),
  .a_flow    (a_flow),
  .a_dout_en (a_dout_en),
  .a_col_n   (a_col_n),
  .b_ce0_n   (b_ce0_n),
  .b_ce1     (b_ce1),
  .b_rw_n    (b_rw_n),
  .b_ads_n   (b_ads_n),
  .b_addr    (b_addr),
  .b_flow    (b_flow),
  .b_dout_en (b_dout_en),
  .b_col_n   (b_col_n)
);

// File: tb/tb_dp_ram_core.sv
`timescale 1ns/1ps
module tb_dp_ram_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic a_ce0_n, a_ce1, a_rw_n, a_ads_n, a_cnten_n, a_rpt_n, a_oe_n, a_flow, a_col_n;
  logic b_ce0_n, b_ce1, b_rw_n, b_ads_n, b_cnten_n, b_rpt_n, b_oe_n, b_flow, b_col_n;
  logic [1:0]  a_be_n, b_be_n, a_dout_en, b_dout_en;
  logic [5:0]  a_addr, b_addr;
  logic [17:0] a_din, b_din, a_dout, b_dout;

  int n_chk = 0;
  int n_fail = 0;

  dp_ram_core dut (.*);

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic ce0_n, input logic ce1, input logic rw_n,
                      input logic [1:0] be_n, input logic [5:0] addr,
                      input logic ads_n, input logic cnten_n, input logic rpt_n,
                      input logic [17:0] din);
    a_ce0_n = ce0_n; a_ce1 = ce1; a_rw_n = rw_n; a_be_n = be_n; a_addr = addr;
    a_ads_n = ads_n; a_cnten_n = cnten_n; a_rpt_n = rpt_n; a_din = din;
  endtask

  task automatic b_op(input logic ce0_n, input logic ce1, input logic rw_n,
                      input logic [1:0] be_n, input logic [5:0] addr,
                      input logic [17:0] din);
    b_ce0_n = ce0_n; b_ce1 = ce1; b_rw_n = rw_n; b_be_n = be_n; b_addr = addr;
    b_ads_n = 1'b0; b_cnten_n = 1'b1; b_rpt_n = 1'b1; b_din = din;
  endtask

  task automatic a_wr(input logic [5:0] ad, input logic [17:0] d, input logic [1:0] be);
    a_op(0, 1, 0, be, ad, 0, 1, 1, d);
  endtask
  task automatic a_rd(input logic [5:0] ad, input logic [1:0] be);
    a_op(0, 1, 1, be, ad, 0, 1, 1, '0);
  endtask
  task automatic a_idle();
    a_op(1, 0, 1, 2'b11, '0, 1, 1, 1, '0);
  endtask
  task automatic b_idle();
    b_op(1, 0, 1, 2'b11, '0, '0);
  endtask

  task automatic t_reset();
    chk("R13 a_dout_en", 32'(a_dout_en), 0);
    chk("R13 b_dout_en", 32'(b_dout_en), 0);
    chk("R13 a_col_n", 32'(a_col_n), 1);
    chk("R13 b_col_n", 32'(b_col_n), 1);
    a_op(0, 1, 0, 2'b00, 6'd33, 1, 1, 1, 18'h2AAAA); step();  // held address 0
    a_rd(0, 2'b00); step();
    chk("R13 address 0", 32'(a_dout), 32'h2AAAA);
    a_idle(); step();
  endtask

  task automatic t_flow_rw();
    a_wr(5, 18'h12345, 2'b00); step();
    chk("R2 write no drive", 32'(a_dout_en), 0);
    a_rd(5, 2'b00); step();
    chk("R3 flow data", 32'(a_dout), 32'h12345);
    chk("R5 strobe en", 32'(a_dout_en), 32'h3);
    a_wr(5, 18'h3FFFF, 2'b10); step();
    a_rd(5, 2'b01); step();
    chk("R3 lane en", 32'(a_dout_en), 32'h2);
    a_rd(5, 2'b00); step();
    chk("R2 lane write", 32'(a_dout), 32'h123FF);
    a_idle(); step();
  endtask

  task automatic t_select();
    a_op(1, 1, 0, 2'b00, 5, 0, 1, 1, 18'h0); step();
    chk("R1 ce0 high", 32'(a_dout_en), 0);
    a_op(0, 0, 1, 2'b00, 5, 0, 1, 1, 18'h0); step();
    chk("R1 ce1 low read", 32'(a_dout_en), 0);
    a_op(0, 0, 0, 2'b00, 5, 0, 1, 1, 18'h0); step();
    a_rd(5, 2'b00); step();
    chk("R1 no write", 32'(a_dout), 32'h123FF);
    a_idle(); step();
  endtask

  task automatic t_pipe();
    b_op(0, 1, 1, 2'b00, 5, '0); step();
    chk("R4 not yet", 32'(b_dout_en), 0);
    b_idle(); step();
    chk("R4 pipe data", 32'(b_dout), 32'h123FF);
    chk("R9 still driven", 32'(b_dout_en), 32'h3);
    step();
    chk("R9 released", 32'(b_dout_en), 0);
    a_rd(5, 2'b00); step();
    chk("R9 flow driven", 32'(a_dout_en), 32'h3);
    a_idle(); step();
    chk("R9 flow released", 32'(a_dout_en), 0);
  endtask

  task automatic t_count();
    a_wr(62, 18'h00062, 2'b00); step();
    a_op(0, 1, 0, 2'b00, 6'd7, 1, 0, 1, 18'h00063); step();
    a_op(0, 1, 0, 2'b00, 6'd7, 1, 0, 1, 18'h00100); step();
    a_rd(63, 2'b00); step();
    chk("R6 count 63", 32'(a_dout), 32'h63);
    a_rd(0, 2'b00); step();
    chk("R6 wrap 0", 32'(a_dout), 32'h100);
    a_rd(62, 2'b00); step();
    chk("R6 base", 32'(a_dout), 32'h62);
    a_idle(); step();
  endtask

  task automatic t_repeat();
    a_wr(10, 18'h000AA, 2'b00); step();
    a_op(0, 1, 0, 2'b00, 6'd3, 1, 0, 1, 18'h000BB); step();
    a_op(0, 1, 1, 2'b00, 6'd3, 1, 0, 0, '0); step();
    chk("R7 replay", 32'(a_dout), 32'hAA);
    a_op(0, 1, 1, 2'b00, 6'd11, 0, 0, 0, '0); step();
    chk("R7 strobe wins", 32'(a_dout), 32'hBB);
    a_idle(); step();
  endtask

  task automatic t_hold();
    a_wr(40, 18'h00333, 2'b00); step();
    a_wr(20, 18'h00111, 2'b00); step();
    a_op(0, 1, 0, 2'b00, 6'd40, 1, 1, 1, 18'h00222); step();
    a_rd(20, 2'b00); step();
    chk("R8 held write", 32'(a_dout), 32'h222);
    a_rd(40, 2'b00); step();
    chk("R8 addr input ignored", 32'(a_dout), 32'h333);
    a_idle(); step();
  endtask

  task automatic t_oe();
    b_op(0, 1, 1, 2'b00, 5, '0); step();
    b_oe_n = 1'b1; b_idle(); step();
    chk("R10 pipe oe off", 32'(b_dout_en), 0);
    b_oe_n = 1'b0; #1;
    chk("R10 pipe oe on", 32'(b_dout_en), 32'h3);
    chk("R10 pipe data", 32'(b_dout), 32'h123FF);
    step();
    a_rd(5, 2'b00); step();
    a_oe_n = 1'b1; #1;
    chk("R10 async off", 32'(a_dout_en), 0);
    a_oe_n = 1'b0; #1;
    chk("R10 async on", 32'(a_dout_en), 32'h3);
    a_idle(); step();
  endtask

  task automatic t_collide();
    a_wr(30, 18'h000A0, 2'b00); b_op(0, 1, 0, 2'b00, 30, 18'h000B0); step();
    chk("R11 a flag", 32'(a_col_n), 0);
    chk("R11 b flag", 32'(b_col_n), 0);
    a_idle(); b_idle(); step();
    chk("R11 one cycle", 32'(a_col_n), 1);
    a_rd(30, 2'b00); step();
    chk("R12 port A wins", 32'(a_dout), 32'hA0);
    b_op(0, 1, 1, 2'b00, 30, '0); step();
    chk("R11 two reads", 32'(b_col_n), 1);
    a_wr(31, 18'h1, 2'b00); b_op(0, 1, 1, 2'b00, 30, '0); step();
    chk("R11 other addr", 32'(a_col_n), 1);
    a_wr(30, 18'h2, 2'b00); b_op(0, 1, 1, 2'b00, 30, '0); step();
    chk("R11 write vs read", 32'(b_col_n), 0);
    a_idle(); b_idle(); step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    a_flow = 1'b1; b_flow = 1'b0; a_oe_n = 1'b0; b_oe_n = 1'b0;
    a_idle(); b_idle();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_flow_rw();
    t_select();
    t_pipe();
    t_count();
    t_repeat();
    t_hold();
    t_oe();
    t_collide();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule